// File: doc/BRIEF.md
# Two-Phase Store Request Sequencer

This block is the CPU-side bus master that turns one memory store into two bus words, sent one after the other on a shared control bus. The first word carries the target address with a write opcode. The second word carries the operand with a no-op opcode, because the memory module already holds the write command. Microcode raises a store strobe with a destination code and an address, and later a data strobe with the operand. The sequencer holds each value in its own output register and raises a low-priority request for the address and a high-priority request for the operand.

The address request can leave only while the destination reports ready and the bus enables are present. The operand request skips the readiness check, because the destination is already waiting for data from this source. Either request leaves on an external grant. When both are pending, the operand goes first. A busy output refuses new stores until both words of the current store have left.

Top module: `store_req_seq`

## Requirements
- R1: After reset, `busy` and `bus_valid` are 0, and `bus_dest`, `bus_src`, `bus_op` and `bus_payload` are all zero.
- R2: A `st_strobe` sampled while `busy` is 0 latches `st_dest` and `st_addr` and raises a pending address request. `busy` reads 1 from the next cycle.
- R3: A pending address request leaves only on a clock edge where `bus_grant`, `dest_ready` and `bus_enable` are all 1 and no operand request is pending. After that edge, `bus_valid` is 1 with `bus_dest` set to the latched destination, `bus_src` set to SRC_ID, `bus_op` set to write (2'b01) and `bus_payload` set to the latched address.
- R4: A `dt_strobe` is taken only while a store is open and its operand has not yet been taken. It latches `dt_data` and raises an operand request. That request leaves on any edge where `bus_grant` is 1, whatever the values of `dest_ready` and `bus_enable`. The word it sends has `bus_op` set to no-op (2'b10) and `bus_payload` set to the operand.
- R5: When both requests are pending on a granted edge, the operand word is sent and the address request stays pending.
- R6: Each request produces exactly one bus word, with `bus_valid` high for one cycle, and then clears. Without a new strobe, later grants send nothing.
- R7: `busy` stays 1 until both words of the open store have left. It falls after the edge that sends the last of them. A `st_strobe` while `busy` is 1 is ignored: the address word that is later sent carries the first store's address and destination.
- R8: A `dt_strobe` while no store is open is ignored, and no operand word follows on later grants.
- R9: While `bus_valid` is 0, `bus_dest`, `bus_src`, `bus_op` and `bus_payload` are zero. The opcode encoding is read 2'b00, write 2'b01, no-op 2'b10, command 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_strobe | input | 1 | Store-address strobe from microcode |
| st_dest | input | 4 | Destination module code for the store |
| st_addr | input | 16 | Store address |
| dt_strobe | input | 1 | Store-operand strobe from microcode |
| dt_data | input | 16 | Store operand |
| dest_ready | input | 1 | Destination module ready |
| bus_enable | input | 1 | Bus enable present |
| bus_grant | input | 1 | Priority grant for this master |
| busy | output | 1 | Store in progress; new stores are refused |
| bus_req | output | 1 | A request is eligible for the bus this cycle |
| bus_valid | output | 1 | Bus word valid, one cycle per transfer |
| bus_dest | output | 4 | Destination code on the bus |
| bus_src | output | 4 | Source code on the bus |
| bus_op | output | 2 | Bus opcode |
| bus_payload | output | 16 | Address or operand word |

## Verification
All results arrive one register stage after their cause. A strobe sampled on an edge shows on `busy` just after that edge, and a grant sampled on an edge puts the bus word out just after that same edge. The bench drives its inputs and then lets exactly one rising edge pass. It compares every output one time unit after that edge against a reference model that updates its state with the same one-edge latency. As a result, every stimulus is checked in the cycle where its effect is due, and a word that comes a cycle early, comes a cycle late or repeats shows up as a miscompare.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_NOP   = 2'b10,
    OP_CMD   = 2'b11
  } bus_op_e;

  // which request wins on a granted edge: operand beats address
  function automatic logic pick_hi(input logic grant, input logic hreq);
    return grant && hreq;
  endfunction

  function automatic logic pick_lo(input logic grant, input logic hreq,
                                   input logic lreq, input logic rdy,
                                   input logic en);
    return grant && !hreq && lreq && rdy && en;
  endfunction
endpackage

// File: rtl/ssq_hold.sv
module ssq_hold #(
  parameter int DEST_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr,
  input  logic              load_data,
  input  logic [DEST_W-1:0] dest_in,
  input  logic [DATA_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [DEST_W-1:0] dest_q,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
      addr_q <= '0;
    end else if (load_addr) begin
      dest_q <= dest_in;
      addr_q <= addr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (load_data) data_q <= data_in;
  end
endmodule

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
  import ssq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic st_strobe,
  input  logic dt_strobe,
  input  logic dest_ready,
  input  logic bus_enable,
  input  logic bus_grant,
  output logic accept_st,
  output logic accept_dt,
  output logic take_hi,
  output logic take_lo,
  output logic eligible,
  output logic busy
);
  logic lreq_q, hreq_q, open_q, dsent_q;
  logic close_now;

  assign accept_st = st_strobe && !open_q;
  assign accept_dt = dt_strobe && open_q && !hreq_q && !dsent_q;
  assign take_hi   = pick_hi(bus_grant, hreq_q);
  assign take_lo   = pick_lo(bus_grant, hreq_q, lreq_q, dest_ready, bus_enable);
  assign eligible  = hreq_q || (lreq_q && dest_ready && bus_enable);
  assign close_now = (take_hi && !lreq_q) || (take_lo && dsent_q);
  assign busy      = open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lreq_q  <= 1'b0;
      hreq_q  <= 1'b0;
      open_q  <= 1'b0;
      dsent_q <= 1'b0;
    end else begin
      if (accept_st)    lreq_q <= 1'b1;
      else if (take_lo) lreq_q <= 1'b0;
      if (accept_dt)    hreq_q <= 1'b1;
      else if (take_hi) hreq_q <= 1'b0;
      if (accept_st)      open_q <= 1'b1;
      else if (close_now) open_q <= 1'b0;
      if (close_now)              dsent_q <= 1'b0;
      else if (take_hi && lreq_q) dsent_q <= 1'b1;
    end
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_hi && take_lo)); // R5
  AST_LO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    take_lo |-> (dest_ready && bus_enable && !hreq_q)); // R3
  AST_HI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take_hi |=> !hreq_q); // R6
  AST_LO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take_lo |=> !lreq_q); // R6
  AST_OPEN_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq_q || hreq_q) |-> open_q); // R7
endmodule

// File: rtl/ssq_bus.sv
module ssq_bus
  import ssq_pkg::*;
#(
  parameter int          DEST_W = 4,
  parameter int          DATA_W = 16,
  parameter logic [3:0]  SRC_ID = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_hi,
  input  logic              take_lo,
  input  logic [DEST_W-1:0] dest_q,
  input  logic [DATA_W-1:0] addr_q,
  input  logic [DATA_W-1:0] data_q,
  output logic              bus_valid,
  output logic [DEST_W-1:0] bus_dest,
  output logic [3:0]        bus_src,
  output logic [1:0]        bus_op,
  output logic [DATA_W-1:0] bus_payload
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_valid   <= 1'b0;
      bus_dest    <= '0;
      bus_src     <= '0;
      bus_op      <= '0;
      bus_payload <= '0;
    end else if (take_hi || take_lo) begin
      bus_valid   <= 1'b1;
      bus_dest    <= dest_q;
      bus_src     <= SRC_ID;
      bus_op      <= take_hi ? OP_NOP : OP_WRITE;
      bus_payload <= take_hi ? data_q : addr_q;
    end else begin
      bus_valid   <= 1'b0;
      bus_dest    <= '0;
      bus_src     <= '0;
      bus_op      <= '0;
      bus_payload <= '0;
    end
  end

  AST_NOP_FOR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    take_hi |=> (bus_valid && bus_op == OP_NOP)); // R4
  AST_WRITE_FOR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    take_lo |=> (bus_valid && bus_op == OP_WRITE)); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (bus_op == 2'b00 && bus_payload == '0 && bus_src == '0)); // R9
endmodule

// File: rtl/store_req_seq.sv
module store_req_seq
  import ssq_pkg::*;
#(
  parameter int         DEST_W = 4,
  parameter int         DATA_W = 16,
  parameter logic [3:0] SRC_ID = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_strobe,
  input  logic [DEST_W-1:0] st_dest,
  input  logic [DATA_W-1:0] st_addr,
  input  logic              dt_strobe,
  input  logic [DATA_W-1:0] dt_data,
  input  logic              dest_ready,
  input  logic              bus_enable,
  input  logic              bus_grant,
  output logic              busy,
  output logic              bus_req,
  output logic              bus_valid,
  output logic [DEST_W-1:0] bus_dest,
  output logic [3:0]        bus_src,
  output logic [1:0]        bus_op,
  output logic [DATA_W-1:0] bus_payload
);
  logic              accept_st, accept_dt, take_hi, take_lo;
  logic [DEST_W-1:0] dest_q;
  logic [DATA_W-1:0] addr_q, data_q;

  ssq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .st_strobe(st_strobe), .dt_strobe(dt_strobe),
    .dest_ready(dest_ready), .bus_enable(bus_enable), .bus_grant(bus_grant),
    .accept_st(accept_st), .accept_dt(accept_dt), .take_hi(take_hi),
    .take_lo(take_lo), .eligible(bus_req), .busy(busy)
  );

  ssq_hold #(.DEST_W(DEST_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_addr(accept_st), .load_data(accept_dt),
    .dest_in(st_dest), .addr_in(st_addr), .data_in(dt_data),
    .dest_q(dest_q), .addr_q(addr_q), .data_q(data_q)
  );

  ssq_bus #(.DEST_W(DEST_W), .DATA_W(DATA_W), .SRC_ID(SRC_ID)) u_bus (
    .clk(clk), .rst_n(rst_n), .take_hi(take_hi), .take_lo(take_lo),
    .dest_q(dest_q), .addr_q(addr_q), .data_q(data_q),
    .bus_valid(bus_valid), .bus_dest(bus_dest), .bus_src(bus_src),
    .bus_op(bus_op), .bus_payload(bus_payload)
  );

  AST_REFUSE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_strobe && busy) |=> $stable(addr_q)); // R7
  AST_BUSY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_strobe && !busy) |=> busy); // R2
  AST_STRAY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_strobe && !busy) |=> $stable(data_q)); // R8
endmodule

// File: tb/test_store_req_seq.sv
module test_store_req_seq;
  localparam logic [3:0] SRC = 4'hA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_strobe = 0, dt_strobe = 0, dest_ready = 0, bus_enable = 0, bus_grant = 0;
  logic [3:0]  st_dest = '0;
  logic [15:0] st_addr = '0, dt_data = '0;
  logic        busy, bus_req, bus_valid;
  logic [3:0]  bus_dest, bus_src;
  logic [1:0]  bus_op;
  logic [15:0] bus_payload;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  // reference state
  bit m_open, m_lreq, m_hreq, m_dsent;
  logic [3:0]  m_dest;
  logic [15:0] m_addr, m_data;
  bit          e_valid;
  logic [3:0]  e_dest, e_src;
  logic [1:0]  e_op;
  logic [15:0] e_pay;

  always #5 clk = ~clk;

  store_req_seq i_store_req_seq (
    .clk(clk), .rst_n(rst_n), .st_strobe(st_strobe), .st_dest(st_dest),
    .st_addr(st_addr), .dt_strobe(dt_strobe), .dt_data(dt_data),
    .dest_ready(dest_ready), .bus_enable(bus_enable), .bus_grant(bus_grant),
    .busy(busy), .bus_req(bus_req), .bus_valid(bus_valid), .bus_dest(bus_dest),
    .bus_src(bus_src), .bus_op(bus_op), .bus_payload(bus_payload)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // address word goes only with ready and enable; operand word needs grant alone
  function automatic bit want_lo(bit g, bit h, bit l, bit r, bit e);
    if (!g || h) return 0;
    return l & r & e;
  endfunction

  task automatic model_edge();
    bit acc_st, acc_dt, hi, lo, close;
    acc_st = st_strobe && !m_open;
    acc_dt = dt_strobe && m_open && !m_hreq && !m_dsent;
    hi     = bus_grant && m_hreq;
    lo     = want_lo(bus_grant, m_hreq, m_lreq, dest_ready, bus_enable);
    close  = (hi && !m_lreq) || (lo && m_dsent);
    e_valid = hi || lo;
    e_dest  = e_valid ? m_dest : 4'h0;
    e_src   = e_valid ? SRC : 4'h0;
    e_op    = hi ? 2'b10 : (lo ? 2'b01 : 2'b00);
    e_pay   = hi ? m_data : (lo ? m_addr : 16'h0);
    if (acc_st) begin m_addr = st_addr; m_dest = st_dest; end
    if (acc_dt) m_data = dt_data;
    if (close) m_dsent = 0; else if (hi && m_lreq) m_dsent = 1;
    if (acc_st) m_lreq = 1; else if (lo) m_lreq = 0;
    if (acc_dt) m_hreq = 1; else if (hi) m_hreq = 0;
    if (acc_st) m_open = 1; else if (close) m_open = 0;
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    #1;
    chk(bus_valid === e_valid, "R6 bus_valid", {31'b0, bus_valid}, {31'b0, e_valid});
    chk(busy === m_open, "R7 busy", {31'b0, busy}, {31'b0, m_open});
    chk(bus_op === e_op, "R4 bus_op", {30'b0, bus_op}, {30'b0, e_op});
    chk(bus_payload === e_pay, "R3 bus_payload", {16'b0, bus_payload}, {16'b0, e_pay});
    chk(bus_dest === e_dest && bus_src === e_src, "R9 dest/src",
        {24'b0, bus_dest, bus_src}, {24'b0, e_dest, e_src});
  endtask

  task automatic idle_in();
    st_strobe = 0; dt_strobe = 0; bus_grant = 0; dest_ready = 0; bus_enable = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++;
      vecs++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_open = 0; m_lreq = 0; m_hreq = 0; m_dsent = 0;
    m_dest = '0; m_addr = '0; m_data = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(busy === 1'b0 && bus_valid === 1'b0, "R1 reset flags", {30'b0, busy, bus_valid}, 0);
    chk(bus_payload === 16'h0 && bus_op === 2'b00, "R1 reset bus", {14'b0, bus_op, bus_payload}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R7: store accepted, second store refused while busy
    st_strobe = 1; st_dest = 4'h3; st_addr = 16'h1111; step();
    chk(busy === 1'b1, "R2 busy after store", {31'b0, busy}, 1);
    st_dest = 4'h5; st_addr = 16'h2222; step();
    // R3: grant without ready sends nothing
    idle_in(); bus_grant = 1; bus_enable = 1; step();
    chk(bus_valid === 1'b0, "R3 no word without ready", {31'b0, bus_valid}, 0);
    dest_ready = 1; step();
    chk(bus_payload === 16'h1111 && bus_dest === 4'h3 && bus_op === 2'b01,
        "R7 first address kept", {12'b0, bus_dest, bus_payload}, {12'b0, 4'h3, 16'h1111});
    // R6: no repeat
    step();
    chk(bus_valid === 1'b0, "R6 no repeat", {31'b0, bus_valid}, 0);
    // R4: operand without readiness
    idle_in(); dt_strobe = 1; dt_data = 16'hBEEF; step();
    idle_in(); bus_grant = 1; step();
    chk(bus_op === 2'b10 && bus_payload === 16'hBEEF, "R4 operand word",
        {14'b0, bus_op, bus_payload}, {14'b0, 2'b10, 16'hBEEF});
    chk(busy === 1'b0, "R7 busy falls", {31'b0, busy}, 0);
    // R8: stray data strobe
    idle_in(); dt_strobe = 1; dt_data = 16'h7777; step();
    idle_in(); bus_grant = 1; step(); step();
    chk(bus_valid === 1'b0, "R8 stray data ignored", {31'b0, bus_valid}, 0);
    // R5: both pending, operand first
    idle_in(); st_strobe = 1; st_dest = 4'h9; st_addr = 16'h0ABC; step();
    idle_in(); dt_strobe = 1; dt_data = 16'h5A5A; step();
    idle_in(); bus_grant = 1; dest_ready = 1; bus_enable = 1; step();
    chk(bus_op === 2'b10, "R5 operand first", {30'b0, bus_op}, {30'b0, 2'b10});
    step();
    chk(bus_op === 2'b01 && bus_payload === 16'h0ABC, "R5 address second",
        {14'b0, bus_op, bus_payload}, {14'b0, 2'b01, 16'h0ABC});
    chk(busy === 1'b0, "R7 busy after both", {31'b0, busy}, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      st_strobe  = ($urandom % 4) == 0;
      dt_strobe  = ($urandom % 4) == 0;
      dest_ready = ($urandom % 3) != 0;
      bus_enable = ($urandom % 4) != 0;
      bus_grant  = ($urandom % 2) == 0;
      st_dest    = 4'($urandom);
      st_addr    = 16'($urandom);
      dt_data    = 16'($urandom);
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule